// File: doc/BRIEF.md
# LCD Serial Register Access Master

This block gives a host bit-serial access to the register file of a display driver chip. It uses four wires: an active-low chip select, a serial clock, a serial data output and a serial data input. The host supplies a 16-bit register address and either an 8-bit parameter to write or a request to read. Each access is carried as three 16-bit frames. Chip select is raised between frames. The first two frames carry the address bytes. The third frame carries the parameter in either direction.

A programmable divider sets the bit rate. The low half of each serial clock cycle, the high half, and the chip-select-high gap after every frame each last the same number of system clock cycles. At the end of an access the block raises a done pulse for one cycle. On a read, the byte returned by the device appears on the read data output in that same cycle.

Top module: `lcd_sreg_master`

## Requirements
- R1: After reset, and whenever busy is low, chip select is high, serial clock and serial data out are low, done is low, and the read data output is 0x00 until the first read completes.
- R2: Every frame is 16 bits shifted out most significant bit first. Bit 15 is the direction flag (1 = read). Bit 14 is the command/parameter flag (1 = parameter). Bit 13 is the address-byte flag (1 = upper address byte). Bits 12 to 8 are zero. Bits 7 to 0 are the payload.
- R3: A write sends exactly three frames, in this order: 0x2000 with the upper address byte, 0x0000 with the lower address byte, and 0x4000 with the parameter byte.
- R4: A read sends the same two address frames, then a third frame of 0xC000 whose payload bits are driven low.
- R5: Chip select goes low for each frame, rises after the frame's 16th clock pulse, and stays high for exactly one phase time after every frame. The serial clock is high only while chip select is low.
- R6: Serial data out changes only while the serial clock is low, and holds steady through every high pulse. The serial clock idles low.
- R7: A phase time is P system clocks, where P is the divider input. One access keeps busy high for exactly 99*P system clocks: three frames of 16 low phases, 16 high phases and one gap each.
- R8: During a read, serial data in is sampled one system clock after each of the last 8 rising serial clock edges of the third frame and assembled most significant bit first. Serial data in is ignored at all other times. The byte appears on the read data output in the cycle done is high.
- R9: Done is high for exactly one cycle per access, and busy falls in that same cycle.
- R10: A start request is accepted only while busy is low. A request made while busy is high produces no extra frame and does not change the frames in progress.
- R11: A completed write leaves the read data output at the value of the last completed read.
- R12: A divider value of zero gives the same timing as a value of one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request one register access |
| rd_req_i | input | 1 | 1 = read access, 0 = write access |
| addr_i | input | 16 | Register address |
| wdata_i | input | 8 | Parameter byte for a write |
| div_i | input | DIV_W (8) | Phase length in system clocks (0 acts as 1) |
| busy_o | output | 1 | Access in progress |
| done_o | output | 1 | One-cycle end-of-access pulse |
| rd_data_o | output | 8 | Byte returned by the last read |
| cs_n_o | output | 1 | Active-low chip select |
| sclk_o | output | 1 | Serial clock, idles low |
| sdo_o | output | 1 | Serial data to the device |
| sdi_i | input | 1 | Serial data from the device |

## Verification
The hardest behaviour to reach from the ports is the read-back window. Serial data in must be taken only in the last eight clock pulses of the third frame, and only on a read. The bench's device model holds serial data in high at every other moment and answers one read with an all-zero byte, so a sample taken outside the window shows up in the result. A second corner is a start request that arrives mid-access. The bench injects one with a different address and direction partway through a write, then checks that exactly three frames from the original request reach the device.

// File: rtl/lsr_pkg.sv
package lsr_pkg;

    localparam int FRAME_W    = 16;
    localparam int BYTE_W     = 8;
    localparam int ADDR_W     = 2 * BYTE_W;
    localparam int NUM_FRAMES = 3;
    localparam int FIDX_W     = $clog2(NUM_FRAMES);
    localparam int BIT_W      = $clog2(FRAME_W);
    localparam int PAD_W      = FRAME_W - BYTE_W - 3;
    localparam logic [FIDX_W-1:0] LAST_FRAME = FIDX_W'(NUM_FRAMES - 1);
    localparam logic [BIT_W-1:0]  LAST_BIT   = BIT_W'(FRAME_W - 1);
    localparam logic [BIT_W-1:0]  FIRST_RX   = BIT_W'(FRAME_W - BYTE_W);

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LOW,
        ST_HIGH,
        ST_GAP
    } lsr_state_e;

    // Frame word: {dir, param, upper_addr, zero pad, payload}
    function automatic logic [FRAME_W-1:0] lsr_frame(
        input logic [FIDX_W-1:0] idx,
        input logic              rd,
        input logic [ADDR_W-1:0] addr,
        input logic [BYTE_W-1:0] wdat
    );
        logic [FRAME_W-1:0] f;
        case (idx)
            2'd0:    f = {3'b001, {PAD_W{1'b0}}, addr[ADDR_W-1:BYTE_W]};
            2'd1:    f = {3'b000, {PAD_W{1'b0}}, addr[BYTE_W-1:0]};
            default: f = {rd, 2'b10, {PAD_W{1'b0}}, rd ? {BYTE_W{1'b0}} : wdat};
        endcase
        return f;
    endfunction

endpackage

// File: rtl/lsr_phase_timer.sv
module lsr_phase_timer #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic [DIV_W-1:0] div_i,
    output logic             phase_end_o
);

    logic [DIV_W-1:0] period;
    logic [DIV_W-1:0] cnt_d, cnt_q;

    always_comb begin
        period      = (div_i == '0) ? DIV_W'(1) : div_i;
        phase_end_o = run_i && (cnt_q >= period - DIV_W'(1));
        cnt_d       = (!run_i || phase_end_o) ? '0 : cnt_q + DIV_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    AST_PHASE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && $stable(div_i)) |-> (cnt_q < period)); // R7

endmodule

// File: rtl/lsr_rx_shift.sv
module lsr_rx_shift #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear_i,
    input  logic         shift_i,
    input  logic         bit_i,
    output logic [W-1:0] data_o
);

    logic [W-1:0] data_d, data_q;

    always_comb begin
        data_d = data_q;
        if (clear_i)      data_d = '0;
        else if (shift_i) data_d = {data_q[W-2:0], bit_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) data_q <= '0;
        else        data_q <= data_d;
    end

    assign data_o = data_q;

endmodule

// File: rtl/lcd_sreg_master.sv
module lcd_sreg_master
    import lsr_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic               rd_req_i,
    input  logic [15:0]        addr_i,
    input  logic [7:0]         wdata_i,
    input  logic [DIV_W-1:0]   div_i,
    output logic               busy_o,
    output logic               done_o,
    output logic [7:0]         rd_data_o,
    output logic               cs_n_o,
    output logic               sclk_o,
    output logic               sdo_o,
    input  logic               sdi_i
);

    typedef struct packed {
        lsr_state_e          st;
        logic [FIDX_W-1:0]   frm;
        logic [BIT_W-1:0]    bitn;
        logic [FRAME_W-1:0]  sh;
        logic                samp;
        logic                busy;
        logic                done;
        logic                rd_op;
        logic [ADDR_W-1:0]   addr;
        logic [BYTE_W-1:0]   wdat;
        logic [BYTE_W-1:0]   rd;
    } lsr_regs_t;

    lsr_regs_t r_d, r_q;

    logic              phase_end;
    logic              rx_clr, rx_shift;
    logic [BYTE_W-1:0] rx_data;

    lsr_phase_timer #(.DIV_W(DIV_W)) u_timer (
        .clk         (clk),
        .rst_n       (rst_n),
        .run_i       (r_q.st != ST_IDLE),
        .div_i       (div_i),
        .phase_end_o (phase_end)
    );

    lsr_rx_shift #(.W(BYTE_W)) u_rx (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (rx_clr),
        .shift_i (rx_shift),
        .bit_i   (sdi_i),
        .data_o  (rx_data)
    );

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        rx_clr   = 1'b0;
        rx_shift = 1'b0;
        case (r_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    r_d.st    = ST_LOW;
                    r_d.frm   = '0;
                    r_d.bitn  = '0;
                    r_d.busy  = 1'b1;
                    r_d.rd_op = rd_req_i;
                    r_d.addr  = addr_i;
                    r_d.wdat  = wdata_i;
                    r_d.sh    = lsr_frame('0, rd_req_i, addr_i, wdata_i);
                    rx_clr    = 1'b1;
                end
            end
            ST_LOW: begin
                if (phase_end) begin
                    r_d.st   = ST_HIGH;
                    r_d.samp = 1'b1;
                end
            end
            ST_HIGH: begin
                r_d.samp = 1'b0;
                // first system clock after the rising serial edge
                if (r_q.samp && r_q.rd_op && r_q.frm == LAST_FRAME && r_q.bitn >= FIRST_RX)
                    rx_shift = 1'b1;
                if (phase_end) begin
                    if (r_q.bitn == LAST_BIT) begin
                        r_d.st = ST_GAP;
                    end else begin
                        r_d.st   = ST_LOW;
                        r_d.bitn = r_q.bitn + BIT_W'(1);
                        r_d.sh   = {r_q.sh[FRAME_W-2:0], 1'b0};
                    end
                end
            end
            ST_GAP: begin
                if (phase_end) begin
                    if (r_q.frm == LAST_FRAME) begin
                        r_d.st   = ST_IDLE;
                        r_d.busy = 1'b0;
                        r_d.done = 1'b1;
                        if (r_q.rd_op) r_d.rd = rx_data;
                    end else begin
                        r_d.st   = ST_LOW;
                        r_d.frm  = r_q.frm + FIDX_W'(1);
                        r_d.bitn = '0;
                        r_d.sh   = lsr_frame(r_q.frm + FIDX_W'(1), r_q.rd_op, r_q.addr, r_q.wdat);
                    end
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{st: ST_IDLE, default: '0};
        else        r_q <= r_d;
    end

    assign busy_o    = r_q.busy;
    assign done_o    = r_q.done;
    assign rd_data_o = r_q.rd;
    assign cs_n_o    = (r_q.st == ST_IDLE) || (r_q.st == ST_GAP);
    assign sclk_o    = (r_q.st == ST_HIGH);
    assign sdo_o     = ((r_q.st == ST_LOW) || (r_q.st == ST_HIGH)) && r_q.sh[FRAME_W-1];

    AST_IDLE_PINS: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (cs_n_o && !sclk_o && !sdo_o)); // R1
    AST_SCLK_FRAMED: assert property (@(posedge clk) disable iff (!rst_n)
        sclk_o |-> !cs_n_o); // R5
    AST_SDO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        sclk_o |-> $stable(sdo_o)); // R6
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R9
    AST_DONE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!busy_o && $past(busy_o))); // R9
    AST_START_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o) |=> busy_o); // R10
    AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> $stable(rd_data_o)); // R11

endmodule

// File: tb/lcd_sreg_master_test.sv
module lcd_sreg_master_test;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0, rd_req = 1'b0;
    logic [15:0] addr = '0;
    logic [7:0]  wdata = '0, div = 8'd1;
    logic        busy, done, cs_n, sclk, sdo;
    logic        sdi = 1'b1;
    logic [7:0]  rd_data;

    int checks = 0, errors = 0;

    // {rd, addr, data (write byte or device reply), divider}
    localparam logic [32:0] VEC [NVEC] = '{
        {1'b0, 16'hC000, 8'h86, 8'd1},
        {1'b1, 16'hC700, 8'hA5, 8'd2},
        {1'b0, 16'h3A00, 8'h66, 8'd3},
        {1'b1, 16'h1234, 8'h00, 8'd1},
        {1'b1, 16'hFFFF, 8'h3C, 8'd0}
    };

    always #(CLK_PERIOD/2) clk = ~clk;

    lcd_sreg_master #(.DIV_W(8)) uut (
        .clk(clk), .rst_n(rst_n), .start_i(start), .rd_req_i(rd_req),
        .addr_i(addr), .wdata_i(wdata), .div_i(div),
        .busy_o(busy), .done_o(done), .rd_data_o(rd_data),
        .cs_n_o(cs_n), .sclk_o(sclk), .sdo_o(sdo), .sdi_i(sdi)
    );

    // device model
    logic [15:0] dev_sh = '0;
    int          dev_bits = 0;
    logic [15:0] cap [8];
    int          cap_bits [8];
    int          ncap = 0;
    logic [7:0]  resp = '0;
    logic        dev_read = 1'b0;

    always @(negedge cs_n) begin dev_bits = 0; dev_sh = '0; end
    always @(posedge sclk) begin dev_sh = {dev_sh[14:0], sdo}; dev_bits++; end
    always @(posedge cs_n) begin
        if (dev_bits > 0 && ncap < 8) begin
            cap[ncap] = dev_sh; cap_bits[ncap] = dev_bits; ncap++;
        end
        dev_bits = 0;
        #1 sdi = 1'b1;
    end
    always @(negedge sclk) begin
        #1 sdi = (dev_read && ncap == 2 && dev_bits >= 8 && dev_bits < 16) ? resp[15-dev_bits] : 1'b1;
    end

    // chip-select-high gap monitor
    int gcnt = 0, gmin = 0, gmax = 0;
    always @(negedge clk) begin
        if (busy && cs_n) gcnt++;
        else if (gcnt > 0) begin
            if (gcnt < gmin) gmin = gcnt;
            if (gcnt > gmax) gmax = gcnt;
            gcnt = 0;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    logic [7:0] last_rd = 8'h00;

    task automatic do_access(input logic rw, input logic [15:0] a, input logic [7:0] d,
                             input logic [7:0] dv, input bit inject);
        int cyc;
        int p;
        logic [15:0] ef [3];
        p = (dv == 0) ? 1 : int'(dv);
        ef[0] = {3'b001, 5'b0, a[15:8]};
        ef[1] = {3'b000, 5'b0, a[7:0]};
        ef[2] = rw ? 16'hC000 : {3'b010, 5'b0, d};
        @(negedge clk);
        ncap = 0; resp = d; dev_read = rw; gmin = 1000000; gmax = 0;
        div = dv; rd_req = rw; addr = a; wdata = d; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cyc = 0;
        while (!done && cyc < 5000) begin
            if (busy) cyc++;
            if (inject && cyc == 10) begin
                start = 1'b1; rd_req = ~rw; addr = 16'hBEEF; wdata = 8'h99;
            end else start = 1'b0;
            @(negedge clk);
        end
        start = 1'b0;
        chk(cyc == 99 * p, dv == 0 ? "R12" : "R7", "busy cycles", cyc, 99 * p);
        chk(done && !busy, "R9", "busy low with done", {busy, done}, 2'b01);
        if (rw) begin
            chk(rd_data == d, "R8", "read byte", rd_data, d);
            last_rd = d;
        end else
            chk(rd_data == last_rd, "R11", "rd_data after write", rd_data, last_rd);
        @(negedge clk); #1;
        chk(!done, "R9", "done width", done, 0);
        chk(ncap == 3, inject ? "R10" : "R3", "frame count", ncap, 3);
        for (int k = 0; k < 3; k++) begin
            chk(cap_bits[k] == 16, "R2", "bits in frame", cap_bits[k], 16);
            chk(cap[k] == ef[k], rw ? "R4" : "R3", "frame word", cap[k], ef[k]);
        end
        chk(gmin == p && gmax == p, "R5", "cs gap", {gmin[15:0], gmax[15:0]}, {p[15:0], p[15:0]});
        repeat (3) @(negedge clk);
        chk(!busy && cs_n && !sclk && !sdo, "R10", "stays idle after access",
            {busy, cs_n, sclk, sdo}, 4'b0100);
    endtask

    task automatic run_all();
        repeat (3) @(negedge clk);
        chk(cs_n && !sclk && !sdo && !busy && !done && rd_data == 0, "R1", "reset pins",
            {cs_n, sclk, sdo, busy, done, rd_data}, 13'h1000);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(cs_n && !sclk && !sdo && !busy, "R1", "idle after release",
            {cs_n, sclk, sdo, busy}, 4'b1000);
        for (int i = 0; i < NVEC; i++)
            do_access(VEC[i][32], VEC[i][31:16], VEC[i][15:8], VEC[i][7:0], 1'b0);
        // start request while busy must be ignored
        do_access(1'b0, 16'hB600, 8'h30, 8'd1, 1'b1);
        // zero reply read followed by a write
        do_access(1'b1, 16'h0A0B, 8'h00, 8'd2, 1'b0);
        do_access(1'b0, 16'h2900, 8'hFF, 8'd0, 1'b0);
    endtask

    initial begin
        fork
            run_all();
            begin
                repeat (150000) @(posedge clk);
                errors++;
                checks++;
                $display("FAIL watchdog R7: actual timeout expected completion");
            end
        join_any
        disable fork;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule